// File: doc/BRIEF.md
# Statically Scheduled Mesh Router Node

This block is the communication half of one node in a two-dimensional array of processors. It has four neighbor links (north, east, south, west) and a port toward its own processor. No word carries a routing header and nothing is arbitrated at run time: a small schedule store, filled before the node runs, holds a cyclic list of crossbar settings. A slot counter steps through the list once per clock, and in each slot the active entry says which source feeds each output.

Words leaving toward a neighbor pass through one register per link, so a word advances exactly one node per clock. A path across several nodes takes one clock per node crossed. The local processor talks to the node through two FIFOs: it pushes into an outbound FIFO and pops from an inbound FIFO, so it can run at a different rate from the router. The schedule and its length are written only while the node is halted. Leaving halt starts the schedule again from entry 0.

Top module: `mesh_sched_router`

## Requirements
- R1: After reset all neighbor outputs are invalid, `rx_valid_o`, `tx_full_o` and `ovf_o` are low, and every schedule entry is idle, so running an unloaded node forwards only bubbles.
- R2: A valid word on a neighbor input in a running cycle appears on each neighbor output whose entry selects that input on the next clock, with its valid bit set.
- R3: One source may feed several outputs in the same slot, and each output carries only the source its own field selects.
- R4: An output whose source is invalid carries a bubble: valid low and data all zero, never an earlier word.
- R5: A slot that selects the local outbound FIFO pops exactly one word, however many outputs take it. An empty outbound FIFO gives a bubble. `tx_full_o` rises once FIFO_DEPTH words are held, and a push while full is dropped.
- R6: A word routed to the local inbound FIFO is visible on `rx_data_o` with `rx_valid_o` high one clock later, and words leave in arrival order on `rx_pop_i`.
- R7: A valid word routed to the inbound FIFO while it is full is dropped, and `ovf_o` is set and stays set until reset.
- R8: Entry field bits [2:0] drive the north output, [5:3] east, [8:6] south, [11:9] west and [14:12] the local inbound FIFO. Codes 0 to 3 select the north, east, south and west inputs, and code 4 selects the local outbound FIFO. The slot counter runs through entries 0 to length-1 and wraps. A written length of 0 or above DEPTH means DEPTH.
- R9: Entry and length writes take effect only while `halt_i` is high. While halted every output is a bubble and neither FIFO is popped or pushed by the crossbar. The first running cycle after halt uses entry 0.
- R10: Codes 5, 6 and 7 are idle and give a bubble on that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Halt: stops routing, allows loading |
| ld_we_i | input | 1 | Write one schedule entry |
| ld_addr_i | input | 4 | Entry index to write |
| ld_entry_i | input | 15 | Entry value, five 3-bit source selects |
| ld_len_we_i | input | 1 | Write schedule length |
| ld_len_i | input | 5 | Schedule length |
| nb_valid_i | input | 4 | Neighbor input valid bits, bit 0 north to bit 3 west |
| nb_data_i | input | 32 | Neighbor input words, 8 bits per port, north lowest |
| nb_valid_o | output | 4 | Registered neighbor output valid bits |
| nb_data_o | output | 32 | Registered neighbor output words |
| tx_push_i | input | 1 | Processor push into outbound FIFO |
| tx_data_i | input | 8 | Word pushed |
| tx_full_o | output | 1 | Outbound FIFO full |
| rx_pop_i | input | 1 | Processor pop from inbound FIFO |
| rx_data_o | output | 8 | Head of inbound FIFO |
| rx_valid_o | output | 1 | Inbound FIFO holds a word |
| ovf_o | output | 1 | Sticky inbound overflow flag |

## Verification
The hardest state to reach is an inbound overflow that comes together with an empty outbound FIFO and a single pop shared by two outputs, because all of these depend on what the processor has pushed and popped and on which slot is active. The stimulus loads a two-entry schedule whose first slot broadcasts the outbound FIFO to two links and sends the north input inward, and whose second slot sends the east input inward. It pushes only two words and never pops, so by the fifth running cycle the outbound side is empty and the inbound side is full in the same slot. Halting in the middle of the schedule and then releasing it shows that the restart begins at entry 0, and writes issued while running are shown to have no effect by the later routing pattern.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NB     = 4;          // neighbor links
  localparam int NOUT   = NB + 1;     // plus local inbound FIFO
  localparam int SEL_W  = 3;
  localparam int ENTRY_W = NOUT * SEL_W;

  localparam logic [SEL_W-1:0] SRC_N    = 3'd0;
  localparam logic [SEL_W-1:0] SRC_E    = 3'd1;
  localparam logic [SEL_W-1:0] SRC_S    = 3'd2;
  localparam logic [SEL_W-1:0] SRC_W    = 3'd3;
  localparam logic [SEL_W-1:0] SRC_LOC  = 3'd4;
  localparam logic [SEL_W-1:0] SRC_IDLE = 3'd7;
endpackage

// File: rtl/msr_fifo.sv
module msr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_full_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);
endmodule

// File: rtl/msr_sched.sv
module msr_sched
  import msr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_i,
  input  logic               ld_we_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic [ENTRY_W-1:0] ld_entry_i,
  input  logic               ld_len_we_i,
  input  logic [LEN_W-1:0]   ld_len_i,
  output logic [ENTRY_W-1:0] entry_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [LEN_W-1:0]   len_q, len_last;
  logic [ADDR_W-1:0]  slot_q;
  logic               at_last;

  assign len_last = len_q - 1'b1;
  assign at_last  = (LEN_W'(slot_q) == len_last);
  assign entry_o  = mem_q[slot_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= {NOUT{SRC_IDLE}};
      len_q <= LEN_W'(DEPTH);
    end else if (halt_i) begin
      if (ld_we_i) mem_q[ld_addr_i] <= ld_entry_i;
      if (ld_len_we_i)
        len_q <= (ld_len_i == '0 || ld_len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : ld_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= '0;
    else if (halt_i)   slot_q <= '0;
    else if (at_last)  slot_q <= '0;
    else               slot_q <= slot_q + 1'b1;
  end

  p_slot_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LEN_W'(slot_q) < len_q);
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && at_last) |=> (slot_q == '0));
  p_load_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i |=> $stable(len_q));
endmodule

// File: rtl/msr_xbar.sv
module msr_xbar
  import msr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     active_i,
  input  logic [ENTRY_W-1:0]       entry_i,
  input  logic [NB-1:0]            nb_valid_i,
  input  logic [NB-1:0][W-1:0]     nb_data_i,
  input  logic                     loc_valid_i,
  input  logic [W-1:0]             loc_data_i,
  output logic [NOUT-1:0]          out_valid_o,
  output logic [NOUT-1:0][W-1:0]   out_data_o,
  output logic                     loc_pop_o
);
  logic [NOUT-1:0]        src_v;
  logic [NOUT-1:0][W-1:0] src_d;
  logic [NOUT-1:0]        use_loc;

  assign src_v = {loc_valid_i, nb_valid_i};
  assign src_d = {loc_data_i, nb_data_i};

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [SEL_W-1:0] sel;
    logic             v;
    assign sel = entry_i[o*SEL_W +: SEL_W];
    assign use_loc[o] = active_i && (sel == SRC_LOC);
    always_comb begin
      v = 1'b0;
      if (active_i && sel <= SRC_LOC) v = src_v[sel];
    end
    assign out_valid_o[o] = v;
    assign out_data_o[o]  = v ? src_d[sel] : '0;
  end

  assign loc_pop_o = (|use_loc) && loc_valid_i;
endmodule

// File: rtl/mesh_sched_router.sv
module mesh_sched_router
  import msr_pkg::*;
#(
  parameter int W          = 8,
  parameter int DEPTH      = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_i,
  input  logic                 ld_we_i,
  input  logic [ADDR_W-1:0]    ld_addr_i,
  input  logic [ENTRY_W-1:0]   ld_entry_i,
  input  logic                 ld_len_we_i,
  input  logic [LEN_W-1:0]     ld_len_i,
  input  logic [NB-1:0]        nb_valid_i,
  input  logic [NB-1:0][W-1:0] nb_data_i,
  output logic [NB-1:0]        nb_valid_o,
  output logic [NB-1:0][W-1:0] nb_data_o,
  input  logic                 tx_push_i,
  input  logic [W-1:0]         tx_data_i,
  output logic                 tx_full_o,
  input  logic                 rx_pop_i,
  output logic [W-1:0]         rx_data_o,
  output logic                 rx_valid_o,
  output logic                 ovf_o
);
  logic [ENTRY_W-1:0]        entry;
  logic [NOUT-1:0]           x_valid;
  logic [NOUT-1:0][W-1:0]    x_data;
  logic                      loc_pop, tx_empty, rx_empty, rx_full;
  logic [W-1:0]              tx_head;
  logic [NB-1:0]             link_v_q;
  logic [NB-1:0][W-1:0]      link_d_q;
  logic                      ovf_q;

  msr_sched #(.DEPTH(DEPTH)) u_sched (
    .clk_i, .rst_ni, .halt_i, .ld_we_i, .ld_addr_i, .ld_entry_i,
    .ld_len_we_i, .ld_len_i, .entry_o(entry)
  );

  msr_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .push_i(tx_push_i), .wdata_i(tx_data_i),
    .pop_i(loc_pop), .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full_o)
  );

  msr_xbar #(.W(W)) u_xbar (
    .active_i(!halt_i), .entry_i(entry), .nb_valid_i, .nb_data_i,
    .loc_valid_i(!tx_empty), .loc_data_i(tx_head),
    .out_valid_o(x_valid), .out_data_o(x_data), .loc_pop_o(loc_pop)
  );

  msr_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(x_valid[NB]), .wdata_i(x_data[NB]),
    .pop_i(rx_pop_i), .rdata_o(rx_data_o), .empty_o(rx_empty), .full_o(rx_full)
  );

  // one register per link: one hop per clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_v_q <= '0;
      link_d_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      link_v_q <= x_valid[NB-1:0];
      link_d_q <= x_data[NB-1:0];
      if (x_valid[NB] && rx_full) ovf_q <= 1'b1;
    end
  end

  assign nb_valid_o = link_v_q;
  assign nb_data_o  = link_d_q;
  assign rx_valid_o = !rx_empty;
  assign ovf_o      = ovf_q;

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_halt_bubble_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (nb_valid_o == '0));
  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !tx_push_i) |=> $stable(tx_empty));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    p_bubble_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nb_valid_o[i] |-> (nb_data_o[i] == '0));
    p_hop_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nb_valid_o[i] |-> $past(!halt_i));
  end
endmodule

// File: tb/mesh_sched_router_tb.sv
module mesh_sched_router_tb;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             halt_i = 1'b1;
  logic             ld_we_i = 1'b0;
  logic [3:0]       ld_addr_i = '0;
  logic [14:0]      ld_entry_i = '0;
  logic             ld_len_we_i = 1'b0;
  logic [4:0]       ld_len_i = '0;
  logic [3:0]       nb_valid_i = '0;
  logic [3:0][7:0]  nb_data_i = '0;
  logic [3:0]       nb_valid_o;
  logic [3:0][7:0]  nb_data_o;
  logic             tx_push_i = 1'b0;
  logic [7:0]       tx_data_i = '0;
  logic             tx_full_o;
  logic             rx_pop_i = 1'b0;
  logic [7:0]       rx_data_o;
  logic             rx_valid_o;
  logic             ovf_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mesh_sched_router u_dut (.*);

  // {in_valid, exp_valid, exp_data(W,S,E,N)}
  localparam logic [39:0] VEC [6] = '{
    {4'b1111, 4'b1101, 32'h01040002},
    {4'b1111, 4'b1111, 32'h13131313},
    {4'b1111, 4'b1011, 32'h22002421},
    {4'b0101, 4'b1000, 32'h31000000},
    {4'b1011, 4'b0000, 32'h00000000},
    {4'b0010, 4'b1000, 32'h52000000}
  };

  function automatic logic [14:0] sched(input logic [2:0] n, e, s, w, l);
    return {l, w, s, e, n};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drive_all(input int k, input logic [3:0] v);
    nb_valid_i = v;
    for (int p = 0; p < 4; p++) nb_data_i[p] = 8'(k * 16 + p + 1);
  endtask

  task automatic load(input logic [3:0] a, input logic [14:0] e);
    ld_we_i = 1'b1; ld_addr_i = a; ld_entry_i = e;
    step();
    ld_we_i = 1'b0;
  endtask

  task automatic load_len(input logic [4:0] n);
    ld_len_we_i = 1'b1; ld_len_i = n;
    step();
    ld_len_we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    tx_push_i = 1'b1; tx_data_i = d;
    step();
    tx_push_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #11 rst_ni = 1'b1;
    step();
    // R1: reset state
    check("R1 nb_valid", 32'(nb_valid_o), 32'h0);
    check("R1 rx_valid", 32'(rx_valid_o), 32'h0);
    check("R1 tx_full", 32'(tx_full_o), 32'h0);
    check("R1 ovf", 32'(ovf_o), 32'h0);
    halt_i = 1'b0; drive_all(15, 4'b1111);
    step();
    check("R1 idle schedule", 32'(nb_valid_o), 32'h0);
    halt_i = 1'b1; drive_all(0, 4'b0000);
    step();

    // R8 schedule of three entries
    load(4'd0, sched(3'd1, 3'd7, 3'd3, 3'd0, 3'd7));
    load(4'd1, sched(3'd2, 3'd2, 3'd2, 3'd2, 3'd7));
    load(4'd2, sched(3'd0, 3'd3, 3'd5, 3'd1, 3'd7));
    load_len(5'd3);

    // vector walk: R2 R3 R4 R8 R10
    halt_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      drive_all(k, VEC[k][39:36]);
      step();
      check($sformatf("R2 R3 R4 R10 vec%0d valid", k), 32'(nb_valid_o), 32'(VEC[k][35:32]));
      check($sformatf("R2 R8 vec%0d data", k), nb_data_o, VEC[k][31:0]);
    end

    // R9: writes while running ignored
    drive_all(0, 4'b0000);
    ld_we_i = 1'b1; ld_addr_i = 4'd0; ld_entry_i = sched(3'd0, 3'd0, 3'd0, 3'd0, 3'd7);
    ld_len_we_i = 1'b1; ld_len_i = 5'd1;
    step();
    ld_we_i = 1'b0; ld_len_we_i = 1'b0;
    step(); step();
    drive_all(6, 4'b1111);
    step();
    check("R9 entry write ignored", nb_data_o, 32'h61640062);
    drive_all(7, 4'b1111);
    step();
    check("R9 length write ignored", nb_data_o, 32'h73737373);

    // R9: halt mid-schedule, restart at entry 0
    halt_i = 1'b1;
    drive_all(7, 4'b1111);
    step();
    check("R9 halted bubble", 32'(nb_valid_o), 32'h0);
    step();
    halt_i = 1'b0; drive_all(8, 4'b1111);
    step();
    check("R9 restart valid", 32'(nb_valid_o), 32'hd);
    check("R9 restart data", nb_data_o, 32'h81840082);
    halt_i = 1'b1; drive_all(0, 4'b0000);
    step();

    // local FIFOs: R5 R6 R7
    load(4'd0, sched(3'd4, 3'd4, 3'd7, 3'd7, 3'd0));
    load(4'd1, sched(3'd7, 3'd7, 3'd7, 3'd7, 3'd1));
    load_len(5'd2);
    push(8'haa);
    push(8'hbb);
    halt_i = 1'b0;
    nb_valid_i = 4'b0001; nb_data_i = '0; nb_data_i[0] = 8'h55;
    step();
    check("R5 broadcast local valid", 32'(nb_valid_o), 32'h3);
    check("R5 broadcast local data", nb_data_o, 32'h0000aaaa);
    check("R6 rx valid next cycle", 32'(rx_valid_o), 32'h1);
    check("R6 rx head", 32'(rx_data_o), 32'h55);
    nb_valid_i = 4'b0010; nb_data_i = '0; nb_data_i[1] = 8'h66;
    step();
    check("R10 idle slot", 32'(nb_valid_o), 32'h0);
    nb_valid_i = 4'b0001; nb_data_i = '0; nb_data_i[0] = 8'h77;
    step();
    check("R5 single pop per slot", nb_data_o, 32'h0000bbbb);
    nb_valid_i = 4'b0010; nb_data_i = '0; nb_data_i[1] = 8'h88;
    step();
    check("R7 no overflow yet", 32'(ovf_o), 32'h0);
    nb_valid_i = 4'b0001; nb_data_i = '0; nb_data_i[0] = 8'h99;
    step();
    check("R5 empty outbound bubble", 32'(nb_valid_o), 32'h0);
    check("R7 overflow set", 32'(ovf_o), 32'h1);
    halt_i = 1'b1; nb_valid_i = '0; nb_data_i = '0;
    step();
    for (int i = 0; i < 4; i++) begin
      logic [7:0] exp_w;
      exp_w = (i == 0) ? 8'h55 : (i == 1) ? 8'h66 : (i == 2) ? 8'h77 : 8'h88;
      check($sformatf("R6 rx order %0d", i), {23'h0, rx_valid_o, rx_data_o}, {24'h1, exp_w});
      rx_pop_i = 1'b1;
      step();
      rx_pop_i = 1'b0;
    end
    check("R7 dropped word absent", 32'(rx_valid_o), 32'h0);
    check("R7 overflow sticky", 32'(ovf_o), 32'h1);

    // R5: outbound full, extra push dropped
    for (int i = 0; i < 5; i++) push(8'(8'h11 + i));
    check("R5 tx full", 32'(tx_full_o), 32'h1);
    halt_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (i < 4) begin
        check($sformatf("R5 drain %0d", i), {28'h0, nb_valid_o}, 32'h3);
        check($sformatf("R5 drain data %0d", i), 32'(nb_data_o[0]), 32'(8'h11 + i));
      end else begin
        check("R5 push while full dropped", 32'(nb_valid_o), 32'h0);
      end
      step();
    end
    halt_i = 1'b1;
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule